// File: doc/BRIEF.md
# Source Range Block Memory

This block produces a latched command that blocks the source-range channel, so that its high-voltage supply is de-energized once reactor power has risen. The command is set by a 2-of-4 coincidence vote. The automatic high-power permissive is wired to two of the four vote legs in parallel, so it satisfies the vote on its own. The manual block request and the low-power permissive each drive a single leg, and neither can set the command alone. Once the command is set, an internal feedback term holds it until a hold-clear input removes that term.

All functional inputs and the output are active low. The inputs are sampled on the rising clock edge and the command is registered, so every change appears one clock after the inputs that cause it. Two active-high fault-injection controls can each open one of the two parallel high-power paths. With them, a test procedure can prove that each path works: it holds hold-clear active, raises the permissive, and checks that the command sets and then drops again when the permissive is released.

Top module: `srb_memory`

## Requirements
- R1: While `rst_n` is low, `blk_cmd_n` is high (inactive), whatever the other inputs are.
- R2: When both parallel paths are intact, a low `hipwr_perm_n` on its own drives `blk_cmd_n` low.
- R3: When `path_open[0]` or `path_open[1]` is 1, a low `hipwr_perm_n` on its own no longer sets `blk_cmd_n`. With `hold_clr_n` low, the output stays high.
- R4: A low `man_req_n` alone, or a low `lopwr_perm_n` alone, does not set `blk_cmd_n`.
- R5: `man_req_n` and `lopwr_perm_n` low together drive `blk_cmd_n` low.
- R6: Once `blk_cmd_n` is low and `hold_clr_n` is high, it stays low after every request input returns high.
- R7: When `hold_clr_n` is low and fewer than two vote legs are active, `blk_cmd_n` goes high on the next clock.
- R8: When `hold_clr_n` is low and a pair of legs is active, `blk_cmd_n` is low. Releasing the pair while `hold_clr_n` is still low drives it high on the next clock.
- R9: When one high-power path is open, the remaining path together with `man_req_n` low still forms a pair and sets `blk_cmd_n`.
- R10: `blk_cmd_n` changes exactly one rising edge after the inputs that cause the change. Between edges it does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hipwr_perm_n | input | 1 | High-power permissive, active low, feeds two parallel legs |
| lopwr_perm_n | input | 1 | Low-power permissive, active low, one leg |
| man_req_n | input | 1 | Manual block request, active low, one leg |
| hold_clr_n | input | 1 | Removes the feedback hold term, active low |
| path_open | input | PAR_PATHS | Fault injection, bit k=1 opens parallel high-power path k |
| blk_cmd_n | output | 1 | Registered source-range block command, active low |

## Verification
The bench targets the parallel high-power paths. It opens each path in turn while hold-clear is held. A design that let one path meet the vote would still set the command, and so would hide a dead path. It checks that a single manual or low-power leg cannot set the command. A design that counted the feedback or a single leg as a pair would latch wrongly. It also checks the hold and clear ordering. If clear were ignored, the command would stick. If clear overrode an active pair, or if the hold did not survive removal of the inputs, the command would drop. It also samples between edges to catch an output that is combinational rather than registered.

// File: rtl/srb_pkg.sv
package srb_pkg;
  // leg positions inside the vote vector after the parallel paths
  localparam int unsigned LEG_OFS_MANUAL = 0;
  localparam int unsigned LEG_OFS_LOPWR  = 1;
  localparam int unsigned SINGLE_LEGS    = 2;

  // active-low pin to active-high term
  function automatic logic act_of(input logic pin_n);
    return ~pin_n;
  endfunction

  // one parallel path conducts when the permissive is present and the path is not opened
  function automatic logic path_term(input logic perm_act, input logic opened);
    return perm_act & ~opened;
  endfunction
endpackage

// File: rtl/srb_leg_front.sv
module srb_leg_front
  import srb_pkg::*;
#(
  parameter int unsigned PAR_PATHS = 2,
  localparam int unsigned NUM_LEGS = PAR_PATHS + SINGLE_LEGS
) (
  input  logic                 hipwr_perm_n,
  input  logic                 lopwr_perm_n,
  input  logic                 man_req_n,
  input  logic [PAR_PATHS-1:0] path_open,
  output logic [NUM_LEGS-1:0]  legs
);
  logic hipwr_act;
  assign hipwr_act = act_of(hipwr_perm_n);

  for (genvar k = 0; k < PAR_PATHS; k++) begin : g_par
    assign legs[k] = path_term(hipwr_act, path_open[k]);
  end

  assign legs[PAR_PATHS + LEG_OFS_MANUAL] = act_of(man_req_n);
  assign legs[PAR_PATHS + LEG_OFS_LOPWR]  = act_of(lopwr_perm_n);
endmodule

// File: rtl/srb_vote.sv
module srb_vote #(
  parameter int unsigned NUM_LEGS = 4,
  parameter int unsigned VOTE_MIN = 2,
  localparam int unsigned CW = $clog2(NUM_LEGS + 1)
) (
  input  logic [NUM_LEGS-1:0] legs,
  output logic [CW-1:0]       vote_cnt,
  output logic                vote_met
);
  function automatic logic [CW-1:0] tally(input logic [NUM_LEGS-1:0] v);
    logic [CW-1:0] s;
    s = '0;
    for (int i = 0; i < NUM_LEGS; i++) s = s + CW'(v[i]);
    return s;
  endfunction

  assign vote_cnt = tally(legs);
  assign vote_met = (int'(vote_cnt) >= int'(VOTE_MIN));
endmodule

// File: rtl/srb_hold.sv
module srb_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic vote_met,
  input  logic clr_act,
  output logic blk_act
);
  logic hold_term;
  logic nxt;

  assign hold_term = blk_act & ~clr_act;
  assign nxt       = vote_met | hold_term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_act <= 1'b0;
    else        blk_act <= nxt;
  end

  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_act && !clr_act) |=> blk_act);
  // R7
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_act && !vote_met) |=> !blk_act);
  // R8
  vote_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vote_met |=> blk_act);
endmodule

// File: rtl/srb_memory.sv
module srb_memory
  import srb_pkg::*;
#(
  parameter int unsigned PAR_PATHS = 2,
  parameter int unsigned VOTE_MIN  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hipwr_perm_n,
  input  logic                 lopwr_perm_n,
  input  logic                 man_req_n,
  input  logic                 hold_clr_n,
  input  logic [PAR_PATHS-1:0] path_open,
  output logic                 blk_cmd_n
);
  localparam int unsigned NUM_LEGS = PAR_PATHS + SINGLE_LEGS;
  localparam int unsigned CW       = $clog2(NUM_LEGS + 1);

  logic [NUM_LEGS-1:0] legs;
  logic [CW-1:0]       vote_cnt;
  logic                vote_met;
  logic                blk_act;

  srb_leg_front #(.PAR_PATHS(PAR_PATHS)) u_front (
    .hipwr_perm_n (hipwr_perm_n),
    .lopwr_perm_n (lopwr_perm_n),
    .man_req_n    (man_req_n),
    .path_open    (path_open),
    .legs         (legs)
  );

  srb_vote #(.NUM_LEGS(NUM_LEGS), .VOTE_MIN(VOTE_MIN)) u_vote (
    .legs     (legs),
    .vote_cnt (vote_cnt),
    .vote_met (vote_met)
  );

  srb_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .vote_met (vote_met),
    .clr_act  (act_of(hold_clr_n)),
    .blk_act  (blk_act)
  );

  assign blk_cmd_n = ~blk_act;

  // R1
  rst_idle_chk: assert property (@(posedge clk) !rst_n |=> blk_cmd_n);
  // R3
  path_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((path_open != '0) && man_req_n && lopwr_perm_n && !hold_clr_n) |=> blk_cmd_n);
  // R4
  single_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hipwr_perm_n && (man_req_n ^ lopwr_perm_n) && !hold_clr_n) |=> blk_cmd_n);
  // R2
  auto_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hipwr_perm_n && (path_open == '0)) |=> !blk_cmd_n);
endmodule

// File: tb/sim_srb_memory.sv
module sim_srb_memory;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hipwr_perm_n = 1'b1;
  logic       lopwr_perm_n = 1'b1;
  logic       man_req_n = 1'b1;
  logic       hold_clr_n = 1'b1;
  logic [1:0] path_open = 2'b00;
  logic       blk_cmd_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  srb_memory u0 (
    .clk(clk), .rst_n(rst_n), .hipwr_perm_n(hipwr_perm_n),
    .lopwr_perm_n(lopwr_perm_n), .man_req_n(man_req_n),
    .hold_clr_n(hold_clr_n), .path_open(path_open), .blk_cmd_n(blk_cmd_n)
  );

  task automatic check(input string req, input logic exp);
    n_chk++;
    if (blk_cmd_n !== exp) begin
      n_bad++;
      $display("FAIL %s: blk_cmd_n actual %b expected %b", req, blk_cmd_n, exp);
    end
  endtask

  // drive at negedge: hi, lo, man, clr are the pin levels
  task automatic drive(input logic hi, input logic lo, input logic man,
                       input logic clr, input logic [1:0] po);
    hipwr_perm_n = hi; lopwr_perm_n = lo; man_req_n = man;
    hold_clr_n = clr; path_open = po;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic flush();
    drive(1, 1, 1, 0, 2'b00); step(1);
    drive(1, 1, 1, 1, 2'b00); step(1);
  endtask

  task automatic t_reset();
    drive(0, 0, 0, 1, 2'b00);
    step(2);
    check("R1 reset dominates", 1'b1);
    rst_n = 1'b1;
    drive(1, 1, 1, 1, 2'b00);
    step(1);
    check("R1 idle after reset", 1'b1);
  endtask

  task automatic t_auto();
    drive(0, 1, 1, 1, 2'b00);
    check("R10 no change before edge", 1'b1);
    step(1);
    check("R2 permissive alone sets", 1'b0);
    drive(1, 1, 1, 1, 2'b00);
    step(3);
    check("R6 hold after release", 1'b0);
    drive(1, 1, 1, 0, 2'b00);
    check("R10 clear waits for edge", 1'b0);
    step(1);
    check("R7 clear drops", 1'b1);
    drive(1, 1, 1, 1, 2'b00); step(1);
    check("R7 stays clear", 1'b1);
  endtask

  task automatic t_fault();
    for (int k = 0; k < 3; k++) begin
      logic [1:0] po;
      po = (k == 0) ? 2'b01 : (k == 1) ? 2'b10 : 2'b11;
      drive(0, 1, 1, 0, po); step(3);
      check("R3 open path blocks set", 1'b1);
      flush();
    end
  endtask

  task automatic t_single();
    drive(1, 1, 0, 1, 2'b00); step(3);
    check("R4 manual alone", 1'b1);
    flush();
    drive(1, 0, 1, 1, 2'b00); step(3);
    check("R4 low permissive alone", 1'b1);
    flush();
  endtask

  task automatic t_pair();
    drive(1, 0, 0, 1, 2'b00); step(1);
    check("R5 manual plus low permissive", 1'b0);
    drive(1, 1, 1, 1, 2'b00); step(2);
    check("R6 pair released held", 1'b0);
    flush();
    check("R7 cleared after pair", 1'b1);
  endtask

  task automatic t_clr_pair();
    drive(0, 1, 1, 0, 2'b00); step(2);
    check("R8 pair overrides clear", 1'b0);
    drive(1, 1, 1, 0, 2'b00); step(1);
    check("R8 release under clear drops", 1'b1);
    drive(1, 1, 1, 1, 2'b00); step(1);
  endtask

  task automatic t_mixed();
    drive(0, 1, 0, 0, 2'b01); step(1);
    check("R9 open path plus manual", 1'b0);
    flush();
    drive(0, 1, 0, 0, 2'b10); step(1);
    check("R9 other path plus manual", 1'b0);
    flush();
    check("R9 cleared", 1'b1);
  endtask

  initial begin : wdog
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_auto();
    t_fault();
    t_single();
    t_pair();
    t_clr_pair();
    t_mixed();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule